// File: doc/BRIEF.md
# Debug Trace Qualification Controller

This block sits between two bus masters (a main CPU and a coprocessor) and a debug trace buffer. It decides, every clock, whether one of the observed bus events should be written into trace memory. If an event qualifies, the block raises a one-cycle store strobe together with the chosen entry: its address, its data and a bit that says which master produced it.

An 8-bit control register sets the behaviour. Its four 2-bit fields are:

- the trace source;
- an address window for the CPU;
- the trace mode (change-of-flow capture, loop capture with repeat suppression, or capture of every access);
- a trigger-alignment setting. The alignment field is only held and read back.

Writes to the register are locked field by field, depending on the secure and armed flags. Debug software programs the register while the block is disarmed. It then raises the armed flag, and the block qualifies events until the flag drops.

Top module: `trace_qual_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00 and `st_vld` is low.
- R2: Bits 7:6 of the control register (trace source) change on a write only while both `secure` and `armed` are low. A write made while `secure` is high still updates bits 5:0 if the block is disarmed.
- R3: A write with `reg_wr` high is ignored in full while `armed` is high. While disarmed, bits 5:0 take `reg_wdata[5:0]`. `reg_rdata` always shows the register.
- R4: Source field bits 7:6: 00 stores nothing, 01 stores CPU events, 10 stores coprocessor events, 11 stores both. `st_src` is 0 for a CPU entry and 1 for a coprocessor entry. When both masters qualify in the same cycle, the CPU entry is stored and the coprocessor event is dropped.
- R5: While `secure` is high, no entry is stored, whatever the source field holds.
- R6: Mode field bits 3:2: 00 (normal) and 01 (loop) store only events with the change-of-flow flag set. 10 (detail) stores every valid event. 11 stores nothing.
- R7: With source 01 and detail mode, range field bits 5:4 filter CPU addresses, with both bounds inclusive. 01 keeps addresses ≤ `rng_hi_addr`. 10 keeps addresses ≥ `rng_lo_addr`. 00 and 11 keep all addresses.
- R8: The range field never filters coprocessor events, and it has no effect when the source field is 11.
- R9: In loop mode, an event whose address equals the address of the last stored entry is suppressed. The record of the last entry is cleared whenever `armed` is low.
- R10: With source 11 and detail mode, nothing is stored.
- R11: An entry is stored only while `armed` and `dbg_en` are both high. `st_vld` rises for exactly one clock, in the cycle after the qualifying event, and `st_addr`/`st_data` carry that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| secure | input | 1 | System secured flag |
| armed | input | 1 | Debug session armed flag |
| dbg_en | input | 1 | Debug block enable |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| cpu_vld | input | 1 | CPU event valid |
| cpu_cof | input | 1 | CPU event is a change of flow |
| cpu_addr | input | ADDR_W | CPU event address |
| cpu_data | input | DATA_W | CPU event data |
| cop_vld | input | 1 | Coprocessor event valid |
| cop_cof | input | 1 | Coprocessor event is a change of flow |
| cop_addr | input | ADDR_W | Coprocessor event address |
| cop_data | input | DATA_W | Coprocessor event data |
| rng_lo_addr | input | ADDR_W | Lower bound used by range code 10 |
| rng_hi_addr | input | ADDR_W | Upper bound used by range code 01 |
| st_vld | output | 1 | Store strobe |
| st_src | output | 1 | Source tag of the stored entry (0 CPU, 1 coprocessor) |
| st_addr | output | ADDR_W | Stored entry address |
| st_data | output | DATA_W | Stored entry data |

## Verification
The bench builds the block with ADDR_W = 23 and DATA_W = 8. The 23-bit address lets it drive the top of the space, 0x7FFFFF, and test both inclusive bounds of the address window. The narrow data field keeps the expected entries readable. A scoreboard model predicts every cycle, including cycles with no strobe. This covers the ordering cases: a tie between the masters, a loop-mode repeat that is suppressed, and a repeat that is stored again after re-arming.

// File: rtl/tq_pkg.sv
package tq_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_CPU  = 2'b01,
    SRC_COP  = 2'b10,
    SRC_BOTH = 2'b11
  } tq_src_e;

  typedef enum logic [1:0] {
    RNG_ALL      = 2'b00,
    RNG_BELOW_HI = 2'b01,
    RNG_ABOVE_LO = 2'b10,
    RNG_RSVD     = 2'b11
  } tq_rng_e;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_LOOP   = 2'b01,
    MODE_DETAIL = 2'b10,
    MODE_RSVD   = 2'b11
  } tq_mode_e;

  // Field order is behaviour: software addresses fields by bit position.
  typedef struct packed {
    tq_src_e    src;    // 7:6
    tq_rng_e    rng;    // 5:4
    tq_mode_e   mode;   // 3:2
    logic [1:0] align;  // 1:0
  } tq_cfg_t;

  localparam int TQ_NUM_SRC  = 2;
  localparam int TQ_CPU_LANE = 0;
  localparam int TQ_COP_LANE = 1;
  localparam int TQ_CFG_W    = $bits(tq_cfg_t);

endpackage

// File: rtl/tq_rst_sync.sv
module tq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tq_ctrl_reg.sv
module tq_ctrl_reg
  import tq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                secure,
  input  logic                armed,
  input  logic                wr,
  input  logic [TQ_CFG_W-1:0] wdata,
  output tq_cfg_t             cfg
);

  localparam int SRC_LSB = TQ_CFG_W - 2;

  logic [TQ_CFG_W-1:0] cfg_q;
  logic [TQ_CFG_W-1:0] cfg_d;
  logic                cfg_en;
  logic                src_wr_ok;

  // Clock enable: any accepted write needs the block disarmed.
  assign cfg_en    = wr & ~armed;
  assign src_wr_ok = ~secure;

  always_comb begin
    cfg_d = cfg_q;
    cfg_d[SRC_LSB-1:0] = wdata[SRC_LSB-1:0];
    if (src_wr_ok) begin
      cfg_d[TQ_CFG_W-1:SRC_LSB] = wdata[TQ_CFG_W-1:SRC_LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = tq_cfg_t'(cfg_q);

endmodule

// File: rtl/tq_range_chk.sv
module tq_range_chk
  import tq_pkg::*;
#(
  parameter int ADDR_W = 23
) (
  input  tq_rng_e           rng,
  input  logic              filt_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo_addr,
  input  logic [ADDR_W-1:0] hi_addr,
  output logic              pass
);

  logic le_hi;
  logic ge_lo;

  assign le_hi = (addr <= hi_addr);
  assign ge_lo = (addr >= lo_addr);

  always_comb begin
    pass = 1'b1;
    if (filt_en) begin
      unique case (rng)
        RNG_BELOW_HI: pass = le_hi;
        RNG_ABOVE_LO: pass = ge_lo;
        default:      pass = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/tq_lane.sv
module tq_lane
  import tq_pkg::*;
(
  input  logic     trace_ok,
  input  logic     src_on,
  input  logic     detail_ok,
  input  tq_mode_e mode,
  input  logic     rng_pass,
  input  logic     evt_vld,
  input  logic     evt_cof,
  output logic     cand
);

  logic mode_hit;

  always_comb begin
    unique case (mode)
      MODE_NORMAL, MODE_LOOP: mode_hit = evt_vld & evt_cof;
      MODE_DETAIL:            mode_hit = evt_vld & detail_ok & rng_pass;
      default:                mode_hit = 1'b0;
    endcase
  end

  assign cand = trace_ok & src_on & mode_hit;

endmodule

// File: rtl/tq_store_stage.sv
module tq_store_stage #(
  parameter int ADDR_W  = 23,
  parameter int DATA_W  = 16,
  parameter int NUM_SRC = 2,
  parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           armed,
  input  logic                           loop_mode,
  input  logic [NUM_SRC-1:0]             cand,
  input  logic [NUM_SRC-1:0][ADDR_W-1:0] lane_addr,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] lane_data,
  output logic                           st_vld,
  output logic [SEL_W-1:0]               st_src,
  output logic [ADDR_W-1:0]              st_addr,
  output logic [DATA_W-1:0]              st_data
);

  logic [NUM_SRC-1:0] redundant;
  logic [NUM_SRC-1:0] lane_ok;
  logic [SEL_W-1:0]   sel_d;
  logic               store_d;

  logic               last_vld_q;
  logic               last_vld_d;
  logic [ADDR_W-1:0]  last_addr_q;

  // Per-lane repeat detection against the last stored address.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
    assign redundant[g] = loop_mode & last_vld_q & (lane_addr[g] == last_addr_q);
    assign lane_ok[g]   = cand[g] & ~redundant[g];
  end

  // Fixed priority: the lowest lane index wins.
  always_comb begin
    sel_d = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (lane_ok[i]) begin
        sel_d = SEL_W'(i);
      end
    end
  end

  assign store_d = |lane_ok;

  always_comb begin
    last_vld_d = last_vld_q;
    if (!armed) begin
      last_vld_d = 1'b0;
    end else if (store_d) begin
      last_vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_vld     <= 1'b0;
      last_vld_q <= 1'b0;
    end else begin
      st_vld     <= store_d;
      last_vld_q <= last_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_src      <= '0;
      st_addr     <= '0;
      st_data     <= '0;
      last_addr_q <= '0;
    end else if (store_d) begin
      st_src      <= sel_d;
      st_addr     <= lane_addr[sel_d];
      st_data     <= lane_data[sel_d];
      last_addr_q <= lane_addr[sel_d];
    end
  end

endmodule

// File: rtl/trace_qual_ctrl.sv
module trace_qual_ctrl
  import tq_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              secure,
  input  logic              armed,
  input  logic              dbg_en,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cpu_vld,
  input  logic              cpu_cof,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cop_vld,
  input  logic              cop_cof,
  input  logic [ADDR_W-1:0] cop_addr,
  input  logic [DATA_W-1:0] cop_data,
  input  logic [ADDR_W-1:0] rng_lo_addr,
  input  logic [ADDR_W-1:0] rng_hi_addr,
  output logic              st_vld,
  output logic              st_src,
  output logic [ADDR_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data
);

  localparam int NUM_SRC = TQ_NUM_SRC;

  logic    rst_sync_n;
  tq_cfg_t cfg;
  logic    trace_ok;
  logic    detail_ok;
  logic    cpu_filt_en;
  logic    loop_mode;

  logic [NUM_SRC-1:0]             lane_vld;
  logic [NUM_SRC-1:0]             lane_cof;
  logic [NUM_SRC-1:0][ADDR_W-1:0] lane_addr;
  logic [NUM_SRC-1:0][DATA_W-1:0] lane_data;
  logic [NUM_SRC-1:0]             lane_rng_pass;
  logic [NUM_SRC-1:0]             lane_cand;
  logic [NUM_SRC-1:0]             lane_src_on;

  tq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tq_ctrl_reg u_ctrl_reg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .secure (secure),
    .armed  (armed),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .cfg    (cfg)
  );

  assign reg_rdata = cfg;

  assign trace_ok    = armed & dbg_en & ~secure;
  assign detail_ok   = (cfg.src != SRC_BOTH);
  assign cpu_filt_en = (cfg.src == SRC_CPU) & (cfg.mode == MODE_DETAIL);
  assign loop_mode   = (cfg.mode == MODE_LOOP);

  // Lane order matches the source-field bit order: bit 0 CPU, bit 1 coprocessor.
  assign lane_src_on = cfg.src;

  assign lane_vld[TQ_CPU_LANE]  = cpu_vld;
  assign lane_cof[TQ_CPU_LANE]  = cpu_cof;
  assign lane_addr[TQ_CPU_LANE] = cpu_addr;
  assign lane_data[TQ_CPU_LANE] = cpu_data;
  assign lane_vld[TQ_COP_LANE]  = cop_vld;
  assign lane_cof[TQ_COP_LANE]  = cop_cof;
  assign lane_addr[TQ_COP_LANE] = cop_addr;
  assign lane_data[TQ_COP_LANE] = cop_data;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (g == TQ_CPU_LANE) begin : g_filt
      tq_range_chk #(.ADDR_W(ADDR_W)) u_range (
        .rng     (cfg.rng),
        .filt_en (cpu_filt_en),
        .addr    (lane_addr[g]),
        .lo_addr (rng_lo_addr),
        .hi_addr (rng_hi_addr),
        .pass    (lane_rng_pass[g])
      );
    end else begin : g_nofilt
      assign lane_rng_pass[g] = 1'b1;
    end

    tq_lane u_lane (
      .trace_ok  (trace_ok),
      .src_on    (lane_src_on[g]),
      .detail_ok (detail_ok),
      .mode      (cfg.mode),
      .rng_pass  (lane_rng_pass[g]),
      .evt_vld   (lane_vld[g]),
      .evt_cof   (lane_cof[g]),
      .cand      (lane_cand[g])
    );
  end

  tq_store_stage #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_SRC (NUM_SRC),
    .SEL_W   (1)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .armed     (armed),
    .loop_mode (loop_mode),
    .cand      (lane_cand),
    .lane_addr (lane_addr),
    .lane_data (lane_data),
    .st_vld    (st_vld),
    .st_src    (st_src),
    .st_addr   (st_addr),
    .st_data   (st_data)
  );

endmodule

// File: rtl/tq_checker.sv
module tq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       secure,
  input logic       armed,
  input logic       dbg_en,
  input logic [7:0] reg_rdata,
  input logic       st_vld,
  input logic       st_src
);

  AST_ARMED_WR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(armed) |-> $stable(reg_rdata)); // R3

  AST_SECURE_SRC_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(secure) |-> (reg_rdata[7:6] == $past(reg_rdata[7:6]))); // R2

  AST_SECURE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(secure) |-> !st_vld); // R5

  AST_STORE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    st_vld |-> $past(armed && dbg_en)); // R11

  AST_CPU_TAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vld && !st_src) |-> $past(reg_rdata[6])); // R4

  AST_COP_TAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vld && st_src) |-> $past(reg_rdata[7])); // R4

  AST_DUAL_DETAIL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_rdata[7:6] == 2'b11 && reg_rdata[3:2] == 2'b10) |-> !st_vld); // R10

  AST_RSVD_MODE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_rdata[3:2] == 2'b11) |-> !st_vld); // R6

endmodule

bind trace_qual_ctrl tq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .secure    (secure),
  .armed     (armed),
  .dbg_en    (dbg_en),
  .reg_rdata (reg_rdata),
  .st_vld    (st_vld),
  .st_src    (st_src)
);

// File: tb/trace_qual_ctrl_tb.sv
`timescale 1ns/1ps
module trace_qual_ctrl_tb;

  localparam int AW = 23;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          sec, arm, en;
  logic          reg_wr;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;
  logic          cpu_vld, cpu_cof, cop_vld, cop_cof;
  logic [AW-1:0] cpu_addr, cop_addr, lo, hi;
  logic [DW-1:0] cpu_data, cop_data;
  logic          st_vld, st_src;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;

  trace_qual_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .secure(sec), .armed(arm), .dbg_en(en),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_vld(cpu_vld), .cpu_cof(cpu_cof), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cop_vld(cop_vld), .cop_cof(cop_cof), .cop_addr(cop_addr), .cop_data(cop_data),
    .rng_lo_addr(lo), .rng_hi_addr(hi),
    .st_vld(st_vld), .st_src(st_src), .st_addr(st_addr), .st_data(st_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic          vld;
    logic          src;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    fails  = 0;

  logic [7:0]    mreg;
  logic          mlv;
  logic [AW-1:0] mla;

  function automatic logic in_window(input logic [AW-1:0] a);
    case (mreg[5:4])
      2'b01:   return a <= hi;
      2'b10:   return a >= lo;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic lane_q(input logic is_cpu, input logic v, input logic c,
                                  input logic [AW-1:0] a);
    logic [1:0] s;
    logic [1:0] m;
    logic       on;
    logic       q;
    s  = mreg[7:6];
    m  = mreg[3:2];
    on = is_cpu ? s[0] : s[1];
    if (!(arm && en && !sec && on)) return 1'b0;
    case (m)
      2'b00, 2'b01: q = v && c;
      2'b10:        q = v && (s != 2'b11) && (!(is_cpu && s == 2'b01) || in_window(a));
      default:      q = 1'b0;
    endcase
    if (q && m == 2'b01 && mlv && a == mla) q = 1'b0;
    return q;
  endfunction

  // Driver: predicts this cycle's result, pushes it, advances the model.
  task automatic step(input string tag);
    exp_t e;
    logic qc, qp;
    qc = lane_q(1'b1, cpu_vld, cpu_cof, cpu_addr);
    qp = lane_q(1'b0, cop_vld, cop_cof, cop_addr);
    e  = '0;
    if (qc)      e = {1'b1, 1'b0, cpu_addr, cpu_data};
    else if (qp) e = {1'b1, 1'b1, cop_addr, cop_data};
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (!arm) mlv = 1'b0;
    else if (e.vld) begin mlv = 1'b1; mla = e.addr; end
    if (reg_wr && !arm) begin
      mreg[5:0] = reg_wdata[5:0];
      if (!sec) mreg[7:6] = reg_wdata[7:6];
    end
    @(negedge clk);
  endtask

  // Monitor: compares one predicted item per clock.
  initial begin
    exp_t  e;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (st_vld !== e.vld ||
            (e.vld && (st_src !== e.src || st_addr !== e.addr || st_data !== e.data))) begin
          fails++;
          $display("FAIL %s: got vld=%0b src=%0b addr=%h data=%h, expected vld=%0b src=%0b addr=%h data=%h",
                   t, st_vld, st_src, st_addr, st_data, e.vld, e.src, e.addr, e.data);
        end
      end
    end
  end

  task automatic chk_reg(input string tag);
    checks++;
    if (reg_rdata !== mreg) begin
      fails++;
      $display("FAIL %s: reg_rdata got %h expected %h", tag, reg_rdata, mreg);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v, input string tag);
    reg_wr    = 1'b1;
    reg_wdata = v;
    step(tag);
    reg_wr    = 1'b0;
    chk_reg(tag);
  endtask

  task automatic ev_cpu(input logic c, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input string tag);
    cpu_vld = 1'b1; cpu_cof = c; cpu_addr = a; cpu_data = d;
    step(tag);
    cpu_vld = 1'b0; cpu_cof = 1'b0;
  endtask

  task automatic ev_cop(input logic c, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input string tag);
    cop_vld = 1'b1; cop_cof = c; cop_addr = a; cop_data = d;
    step(tag);
    cop_vld = 1'b0; cop_cof = 1'b0;
  endtask

  task automatic set_arm(input logic v);
    arm = v;
    step("R11 idle");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sec = 1'b0; arm = 1'b0; en = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    cpu_vld = 1'b0; cpu_cof = 1'b0; cpu_addr = '0; cpu_data = '0;
    cop_vld = 1'b0; cop_cof = 1'b0; cop_addr = '0; cop_data = '0;
    lo = 23'h7FFFF0; hi = 23'h000100;
    mreg = '0; mlv = 1'b0; mla = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_reg("R1 reset register");
    checks++;
    if (st_vld !== 1'b0) begin
      fails++;
      $display("FAIL R1: st_vld got %0b expected 0", st_vld);
    end

    // CPU normal mode
    wr_cfg(8'h40, "R3 disarmed write");
    en = 1'b1;
    set_arm(1'b1);
    ev_cpu(1'b1, 23'h001234, 8'hA1, "R6 normal cof stored");
    ev_cpu(1'b0, 23'h001240, 8'hA2, "R6 normal non-cof dropped");
    ev_cop(1'b1, 23'h002000, 8'h05, "R4 cop ignored with cpu source");
    wr_cfg(8'hFF, "R3 armed write ignored");
    en = 1'b0;
    ev_cpu(1'b1, 23'h003000, 8'h06, "R11 disabled no store");
    en = 1'b1;
    set_arm(1'b0);
    ev_cpu(1'b1, 23'h003004, 8'h07, "R11 disarmed no store");

    // Coprocessor detail with a window set
    wr_cfg(8'h98, "R4 cop detail write");
    set_arm(1'b1);
    ev_cop(1'b0, 23'h005000, 8'h11, "R8 cop detail ignores window");
    ev_cpu(1'b1, 23'h000010, 8'h12, "R4 cpu ignored with cop source");
    set_arm(1'b0);

    // Both sources
    wr_cfg(8'hC0, "R4 both normal write");
    set_arm(1'b1);
    cop_vld = 1'b1; cop_cof = 1'b1; cop_addr = 23'h000222; cop_data = 8'h22;
    ev_cpu(1'b1, 23'h000111, 8'h21, "R4 cpu wins tie");
    cop_vld = 1'b0; cop_cof = 1'b0;
    ev_cop(1'b1, 23'h000333, 8'h23, "R4 cop alone stored");
    set_arm(1'b0);

    wr_cfg(8'hC8, "R10 both detail write");
    set_arm(1'b1);
    ev_cpu(1'b1, 23'h000444, 8'h31, "R10 cpu nothing stored");
    ev_cop(1'b0, 23'h000555, 8'h32, "R10 cop nothing stored");
    set_arm(1'b0);

    // CPU detail windows
    wr_cfg(8'h58, "R7 below-hi write");
    set_arm(1'b1);
    ev_cpu(1'b0, 23'h000100, 8'h41, "R7 at upper bound stored");
    ev_cpu(1'b0, 23'h000101, 8'h42, "R7 above upper bound dropped");
    set_arm(1'b0);
    wr_cfg(8'h68, "R7 above-lo write");
    set_arm(1'b1);
    ev_cpu(1'b0, 23'h7FFFF0, 8'h43, "R7 at lower bound stored");
    ev_cpu(1'b0, 23'h7FFFEF, 8'h44, "R7 below lower bound dropped");
    ev_cpu(1'b0, 23'h7FFFFF, 8'h45, "R7 top address stored");
    set_arm(1'b0);
    wr_cfg(8'h78, "R7 reserved window write");
    set_arm(1'b1);
    ev_cpu(1'b0, 23'h400000, 8'h46, "R7 reserved window no filter");
    set_arm(1'b0);

    // Loop mode
    wr_cfg(8'h44, "R9 loop write");
    set_arm(1'b1);
    ev_cpu(1'b1, 23'h000800, 8'h51, "R9 first stored");
    ev_cpu(1'b1, 23'h000800, 8'h52, "R9 repeat suppressed");
    ev_cpu(1'b1, 23'h000900, 8'h53, "R9 new target stored");
    ev_cpu(1'b1, 23'h000800, 8'h54, "R9 earlier target stored");
    set_arm(1'b0);
    set_arm(1'b1);
    ev_cpu(1'b1, 23'h000800, 8'h55, "R9 rearm clears history");
    set_arm(1'b0);

    // Reserved mode
    wr_cfg(8'h4C, "R6 reserved mode write");
    set_arm(1'b1);
    ev_cpu(1'b1, 23'h000A00, 8'h61, "R6 reserved mode nothing stored");
    set_arm(1'b0);

    // Secure
    wr_cfg(8'h40, "R2 source set before secure");
    sec = 1'b1;
    wr_cfg(8'h84, "R2 secure blocks source bits");
    set_arm(1'b1);
    ev_cpu(1'b1, 23'h000B00, 8'h71, "R5 secure no store");
    sec = 1'b0;
    ev_cpu(1'b1, 23'h000B04, 8'h72, "R5 store resumes after secure drops");
    set_arm(1'b0);
    step("R11 drain");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule